// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block times the phases of an external digital pulse. A 16-bit up-counter advances on ticks from a prescaler of the system clock. Each qualifying edge on a pulse input copies the running count into that input's capture register and restarts both the counter and the prescaler from zero. Two consecutive captures on the same input therefore give the durations of the high and low phases directly. If the counter wraps past 0xFFFF, a sticky overflow flag is raised, which lets software resolve a phase that spans at most one wrap.

Software programs the block through a small register port: an enable bit, a 3-bit mode field (only the value 3'b110 runs the width measurement), a 3-bit prescaler select and a 2-bit edge select for each of the two inputs. Only one input is meant to be active at a time, with the other set to detect nothing. Each input also drives a one-cycle capture strobe.

The control sequencer has two states. `ST_IDLE` holds the counter and prescaler at zero and takes no captures. `ST_RUN` counts and captures. The transition START (IDLE to RUN) is taken when enable is 1 and the mode is 3'b110. The transition STOP (RUN to IDLE) is taken as soon as either of those conditions no longer holds.

Top module: `pwc_timer`

## Requirements
- R1: After reset, every register reads 0, the overflow flag is 0, and both capture strobes are 0.
- R2: The counter runs and captures are taken only while enable (address 0 bit 0) is 1 and the mode field (address 0 bits 3:1) is 3'b110. With any other mode, edges produce no strobe and leave the capture registers unchanged.
- R3: A pulse-input change is detected 3 clock edges after it is driven (two synchronizer flops and one edge-detect flop). A detected edge on input i stores the current count in capture register i and clears the counter to 0. For detected edges N clock cycles apart with divider D, the second capture equals floor((N-1)/D).
- R4: The per-input edge select uses 2'b00 for no edges, 2'b01 for rising only, 2'b10 for falling only and 2'b11 for both. Input 0's field is address 0 bits 8:7 and input 1's field is bits 10:9.
- R5: The prescaler select S (address 0 bits 6:4) makes the counter advance once every 2^S clock cycles. The prescaler restarts at each capture and while idle.
- R6: When the counter wraps from 0xFFFF, the overflow flag is set. If a capture occurs in the same cycle, the capture register receives 0xFFFF, the counter clears, and the flag is still set.
- R7: The overflow flag (address 0 bit 11, also on port `ovf_flag`) is cleared by a write to address 0 with bit 11 = 0, and by any capture that is not itself coincident with a wrap.
- R8: Each capture raises that input's strobe for exactly one cycle. The other input's strobe stays 0.
- R9: Clearing enable returns the counter to 0, so that the first capture after re-enabling counts from the enable. The capture registers keep their values across the disable.
- R10: Register map: address 0 holds control and the flag, address 1 reads capture 0, address 2 reads capture 1, and address 3 reads 0. Read data is combinational on the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| pulse_in | input | 2 | Asynchronous pulse inputs |
| cap_stb | output | 2 | One-cycle strobe per input when its capture register updates |
| ovf_flag | output | 1 | Counter overflow flag |

## Verification
The assertions assume that the pulse inputs hold each level for at least three clock cycles, so that every change passes through the synchronizer as a distinct edge. They also assume that a capture and a wrap coincide only in the way R6 describes. The stimulus keeps every gap between toggles at three cycles or more. It drives only one input per scenario, with the other input's edge select set to none. It rewrites control only while the pulses are idle, apart from the deliberate overflow-flag clear, which is timed well away from any wrap.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwc_state_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam logic [2:0] MODE_WIDTH = 3'b110;
endpackage

// File: rtl/pwc_prescaler.sv
module pwc_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = ~({PRE_W{1'b1}} << sel);
    assign tick  = (pre_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tick == (sel == '0)));
endmodule

// File: rtl/pwc_edge_det.sv
module pwc_edge_det
    import pwc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e esel,
    output logic      hit
);
    logic s1_q, s2_q, s3_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
    assign fall = ~s2_q & s3_q;
    assign hit  = (rise & esel[0]) | (fall & esel[1]);

    // R4
    edge_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (esel != EDGE_NONE));
endmodule

// File: rtl/pwc_core.sv
module pwc_core
    import pwc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_req,
    input  logic                       tick,
    input  logic [NCH-1:0]             hit,
    input  logic                       ovf_wr_clr,
    output pwc_state_e                 state_q,
    output logic [NCH-1:0][CNT_W-1:0]  cap_q,
    output logic [NCH-1:0]             cap_stb_q,
    output logic                       ovf_q
);
    pwc_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             any_cap;

    assign any_cap = (state_q == ST_RUN) && (|hit);
    assign wrap    = (state_q == ST_RUN) && tick && (cnt_q == {CNT_W{1'b1}});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_req)  state_d = ST_RUN;
            ST_RUN:  if (!run_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cap_q     <= '0;
            cap_stb_q <= '0;
            ovf_q     <= 1'b0;
        end else begin
            cap_stb_q <= '0;
            unique case (state_q)
                ST_IDLE: cnt_q <= '0;
                ST_RUN: begin
                    if (|hit) begin
                        cnt_q <= '0;
                        for (int i = 0; i < NCH; i++) begin
                            if (hit[i]) begin
                                cap_q[i]     <= cnt_q;
                                cap_stb_q[i] <= 1'b1;
                            end
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
            if (wrap)
                ovf_q <= 1'b1;
            else if (any_cap || ovf_wr_clr)
                ovf_q <= 1'b0;
        end
    end

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (cnt_q == '0));

    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && tick && (cnt_q == {CNT_W{1'b1}})) |=> ovf_q);

    // R8
    stb_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cap_stb_q) |-> ($past(state_q) == ST_RUN));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cap_stb_q) |-> (cnt_q == '0));

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_cap_chk
            // R3
            cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cap_stb_q[g] |-> (cap_q[g] == $past(cnt_q)));
        end
    endgenerate
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer
    import pwc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3,
    parameter int NCH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [NCH-1:0]   pulse_in,
    output logic [NCH-1:0]   cap_stb,
    output logic             ovf_flag
);
    localparam int OVF_BIT = 4 + SEL_W + 2 * NCH;

    logic                      en_q;
    logic [2:0]                mode_q;
    logic [SEL_W-1:0]          sel_q;
    edge_sel_e                 esel_q [NCH];
    logic [NCH-1:0]            hit;
    logic [2*NCH-1:0]          esel_flat;
    logic                      tick;
    logic                      run_req;
    logic                      ovf_wr_clr;
    pwc_state_e                state;
    logic [NCH-1:0][CNT_W-1:0] cap;
    logic                      ctl_wr;

    assign ctl_wr     = reg_wr && (reg_addr == 2'd0);
    assign ovf_wr_clr = ctl_wr && !reg_wdata[OVF_BIT];
    assign run_req    = en_q && (mode_q == MODE_WIDTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= '0;
            sel_q  <= '0;
            for (int i = 0; i < NCH; i++) esel_q[i] <= EDGE_NONE;
        end else if (ctl_wr) begin
            en_q   <= reg_wdata[0];
            mode_q <= reg_wdata[3:1];
            sel_q  <= reg_wdata[4 +: SEL_W];
            for (int i = 0; i < NCH; i++)
                esel_q[i] <= edge_sel_e'(reg_wdata[4 + SEL_W + 2*i +: 2]);
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_in
            assign esel_flat[2*g +: 2] = esel_q[g];
            pwc_edge_det u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (pulse_in[g]),
                .esel  (esel_q[g]),
                .hit   (hit[g])
            );
        end
    endgenerate

    pwc_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state != ST_RUN) || (|hit)),
        .sel   (sel_q),
        .tick  (tick)
    );

    pwc_core #(.CNT_W(CNT_W), .NCH(NCH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_req    (run_req),
        .tick       (tick),
        .hit        (hit),
        .ovf_wr_clr (ovf_wr_clr),
        .state_q    (state),
        .cap_q      (cap),
        .cap_stb_q  (cap_stb),
        .ovf_q      (ovf_flag)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            2'd0: begin
                reg_rdata[0]                 = en_q;
                reg_rdata[3:1]               = mode_q;
                reg_rdata[4 +: SEL_W]        = sel_q;
                reg_rdata[4 + SEL_W +: 2*NCH] = esel_flat;
                reg_rdata[OVF_BIT]           = ovf_flag;
            end
            2'd1: reg_rdata = 16'(cap[0]);
            2'd2: reg_rdata = 16'(cap[NCH-1]);
            default: reg_rdata = '0;
        endcase
    end

    // R2
    no_cap_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_req) && !run_req |-> (cap_stb == '0));
endmodule

// File: tb/sim_pwc_timer.sv
module sim_pwc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [1:0]  pulse_in = 2'b00;
    logic [1:0]  cap_stb;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;
    int stb_cnt0 = 0;
    int stb_cnt1 = 0;
    int cyc = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    pwc_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_in(pulse_in),
        .cap_stb(cap_stb), .ovf_flag(ovf_flag)
    );

    always @(negedge clk) begin
        if (cap_stb[0]) stb_cnt0++;
        if (cap_stb[1]) stb_cnt1++;
    end

    localparam int NV = 8;
    localparam int V_SEL [NV] = '{0, 1, 3, 0, 2, 0, 7, 4};
    localparam int V_CH  [NV] = '{0, 0, 1, 0, 1, 0, 0, 1};
    localparam int V_ES  [NV] = '{3, 3, 3, 1, 1, 2, 3, 2};
    localparam int V_N   [NV] = '{10, 10, 8, 10, 7, 12, 5, 3};
    localparam int V_M   [NV] = '{20, 20, 8, 20, 13, 5, 5, 40};
    localparam int V_P   [NV] = '{30, 31, 100, 5, 9, 6, 300, 41};

    function automatic logic [15:0] ctl(input logic en, input logic [2:0] mode,
        input logic [2:0] sel, input logic [1:0] e0, input logic [1:0] e1);
        return {4'b0, 1'b0, e1, e0, sel, mode, en};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int v;
        int d;
        int ch;
        int exp_cap;
        int exp_stb;
        int keep;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        // R1 / R10: reset values
        rd(2'd0, v); check("R1 ctl", v, 0);
        rd(2'd1, v); check("R1 cap0", v, 0);
        rd(2'd2, v); check("R1 cap1", v, 0);
        rd(2'd3, v); check("R10 addr3", v, 0);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 stb", int'(cap_stb), 0);

        // Vector table: R3 R4 R5 R8
        for (int k = 0; k < NV; k++) begin
            d  = 1 << V_SEL[k];
            ch = V_CH[k];
            wr(2'd0, 16'd0);
            if (ch == 0) wr(2'd0, ctl(1'b1, 3'b110, 3'(V_SEL[k]), 2'(V_ES[k]), 2'b00));
            else         wr(2'd0, ctl(1'b1, 3'b110, 3'(V_SEL[k]), 2'b00, 2'(V_ES[k])));
            wait_n(3);
            stb_cnt0 = 0; stb_cnt1 = 0;
            pulse_in[ch] = 1'b1; wait_n(V_N[k]);
            pulse_in[ch] = 1'b0; wait_n(V_M[k]);
            pulse_in[ch] = 1'b1; wait_n(V_P[k]);
            pulse_in[ch] = 1'b0; wait_n(5);
            if (V_ES[k] == 3)      begin exp_cap = (V_P[k] - 1) / d;          exp_stb = 4; end
            else if (V_ES[k] == 1) begin exp_cap = (V_N[k] + V_M[k] - 1) / d; exp_stb = 2; end
            else                   begin exp_cap = (V_M[k] + V_P[k] - 1) / d; exp_stb = 2; end
            rd(ch == 0 ? 2'd1 : 2'd2, v);
            check($sformatf("R3/R5 vec%0d capture", k), v, exp_cap);
            check($sformatf("R4/R8 vec%0d strobes", k), ch == 0 ? stb_cnt0 : stb_cnt1, exp_stb);
            check($sformatf("R8 vec%0d other strobes", k), ch == 0 ? stb_cnt1 : stb_cnt0, 0);
        end

        // R9: disable keeps capture registers
        rd(2'd1, keep);
        wr(2'd0, 16'd0);
        wait_n(3);
        rd(2'd1, v); check("R9 cap0 kept", v, keep);

        // R2: wrong mode -> no captures
        wr(2'd0, ctl(1'b1, 3'b000, 3'd0, 2'b11, 2'b00));
        stb_cnt0 = 0;
        pulse_in[0] = 1'b1; wait_n(10);
        pulse_in[0] = 1'b0; wait_n(6);
        check("R2 no strobe", stb_cnt0, 0);
        rd(2'd1, v); check("R2 cap0 unchanged", v, keep);

        // R9: re-enable counts from zero; edge 20 cycles after enable -> 21
        wr(2'd0, 16'd0);
        wr(2'd0, ctl(1'b1, 3'b110, 3'd0, 2'b11, 2'b00));
        wait_n(20);
        pulse_in[0] = 1'b1; wait_n(5);
        rd(2'd1, v); check("R9 restart count", v, 21);

        // R6: overflow flag at the wrap
        pulse_in[0] = 1'b0; wait_n(5);
        wr(2'd0, 16'd0);
        wr(2'd0, ctl(1'b1, 3'b110, 3'd0, 2'b11, 2'b00));
        wait_n(65536);
        check("R6 no flag before wrap", int'(ovf_flag), 0);
        wait_n(1);
        check("R6 flag after wrap", int'(ovf_flag), 1);
        rd(2'd0, v); check("R10 flag bit11", (v >> 11) & 1, 1);

        // R7: software clear
        wr(2'd0, ctl(1'b1, 3'b110, 3'd0, 2'b11, 2'b00));
        check("R7 sw clear", int'(ovf_flag), 0);

        // R6: capture coincident with wrap
        wr(2'd0, 16'd0);
        wr(2'd0, ctl(1'b1, 3'b110, 3'd0, 2'b11, 2'b00));
        wait_n(65534);
        pulse_in[0] = 1'b1; wait_n(3);
        rd(2'd1, v); check("R6 coincident capture", v, 65535);
        check("R6 flag with capture", int'(ovf_flag), 1);
        wait_n(7);
        pulse_in[0] = 1'b0; wait_n(5);
        rd(2'd1, v); check("R3 capture after wrap", v, 9);
        check("R7 capture clears flag", int'(ovf_flag), 0);

        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=done", cyc);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule